// File: doc/BRIEF.md
# Mixed-Width Conditional Call Sequencer

This block carries out the memory side of a conditional subroutine call for a processor that runs either in a legacy 16-bit address mode or in a 24-bit linear address mode. A start strobe hands it a complete request. The request holds the evaluated condition, the current mode bit and a suffix selector. It also holds the three target-address bytes, the address of the instruction that follows the call, a base-page byte, and two stack pointers: a 16-bit short one and a 24-bit long one.

When the condition holds, the block pushes the return address onto the stack that the mode and suffix select, writing one byte per clock over a memory write port. The stacks grow downward, and each push pre-decrements the pointer and stores the most significant byte first. Short-stack addresses take the base-page byte as their upper byte. In 16-bit mode the suffix variant also pushes a marker byte 02h onto the long stack, to record that the call came from 16-bit mode.

When the sequence ends, the block raises a one-cycle done pulse and presents the new program counter, both stack pointers and the unchanged mode bit. Decoding the opcode, evaluating the condition and returning from the call are handled elsewhere.

Top module: `xcall_seq`

## Requirements
- R1: With `cond_true`=0 the block writes nothing. `done` is high in the cycle after the accepting edge. `pc_out` is `next_pc` in 24-bit mode and {`page_base`, `next_pc[15:0]`} in 16-bit mode. Both stack pointer outputs equal their inputs.
- R2: With `wide_mode`=0 and `short_sfx`=0 and the condition true, there are two writes. The first writes `next_pc[15:8]` at {`page_base`, `ssp_in`-1}. The second writes `next_pc[7:0]` at {`page_base`, `ssp_in`-2}. Then `ssp_out`=`ssp_in`-2, `lsp_out`=`lsp_in` and `pc_out`={`page_base`, `tgt_mid`, `tgt_lo`}.
- R3: With `wide_mode`=1 and the condition true, there are three writes: `next_pc[23:16]` at `lsp_in`-1, `next_pc[15:8]` at `lsp_in`-2 and `next_pc[7:0]` at `lsp_in`-3. Then `lsp_out`=`lsp_in`-3, `ssp_out`=`ssp_in` and `pc_out`={`tgt_hi`, `tgt_mid`, `tgt_lo`}.
- R4: With `wide_mode`=0, `short_sfx`=1 and the condition true, the block makes the two writes of R2 and then writes byte 02h at `lsp_in`-1. Then `ssp_out`=`ssp_in`-2, `lsp_out`=`lsp_in`-1 and `pc_out`={`page_base`, `tgt_mid`, `tgt_lo`}.
- R5: With `wide_mode`=1, `short_sfx` has no effect: writes and results are those of R3.
- R6: `wide_out` is loaded with the mode bit of the accepted request and is valid while `done` is high. No call variant changes the mode.
- R7: Writes occur in consecutive cycles starting the cycle after the accepting edge, one byte per cycle. `done` is high for exactly one cycle, the cycle after the last write.
- R8: `start` is accepted only when the block is idle. A start during the write cycles or during the done cycle is ignored and changes neither the writes nor the results.
- R9: The short pointer wraps modulo 2^16, and short-stack addresses keep `page_base` as their upper byte across the wrap. The long pointer wraps modulo 2^24.
- R10: After synchronous reset, `wr_en`, `done`, `pc_out`, `ssp_out`, `lsp_out` and `wide_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| cond_true | input | 1 | Evaluated call condition |
| wide_mode | input | 1 | Address mode: 0 = 16-bit, 1 = 24-bit |
| short_sfx | input | 1 | Suffix selector: 1 = short-stack variant with mode marker |
| tgt_lo | input | 8 | Target address low byte |
| tgt_mid | input | 8 | Target address middle byte |
| tgt_hi | input | 8 | Target address high byte (24-bit mode only) |
| next_pc | input | 24 | Address of the instruction after the call |
| page_base | input | 8 | Base-page byte for 16-bit mode addresses |
| ssp_in | input | 16 | Short stack pointer before the call |
| lsp_in | input | 24 | Long stack pointer before the call |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 24 | Memory write address |
| wr_data | output | 8 | Memory write byte |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 24 | New program counter |
| ssp_out | output | 16 | New short stack pointer |
| lsp_out | output | 24 | New long stack pointer |
| wide_out | output | 1 | Mode bit after the call |

## Verification
The hardest situation to reach is a push that crosses zero on a stack pointer while the address still has to carry the base page. The stimulus table therefore includes short pointers of 0001h and long pointers of 000001h and 000000h, so that a single call writes on both sides of the wrap. A second hard case is a start strobe that arrives while the sequencer is busy. Directed tests raise start during a write cycle with a different request on the inputs, and again during the done cycle. They then check that the original writes and results stand and that no second sequence begins.

// File: rtl/xcall_pkg.sv
package xcall_pkg;

    localparam int BYTE_W  = 8;
    localparam int SHORT_W = 16;
    localparam int ADDR_W  = SHORT_W + BYTE_W;
    localparam int MAX_WR  = 4;
    localparam int SLOT_W  = $clog2(MAX_WR);
    localparam int CNT_W   = $clog2(MAX_WR + 1);
    localparam logic [BYTE_W-1:0] MODE16_MARK = 8'h02;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [SHORT_W-1:0] sptr_t;
    typedef logic [ADDR_W-1:0]  addr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE} st_e;

    typedef enum logic [1:0] {
        FLAV_SKIP,
        FLAV_SHORT,
        FLAV_LONG,
        FLAV_SHORT_MARK
    } flav_e;

    typedef struct packed {
        logic  cond;
        logic  wide;
        logic  sfx;
        byte_t lo;
        byte_t mid;
        byte_t hi;
        addr_t nxt;
        byte_t base;
        sptr_t ssp;
        addr_t lsp;
    } req_t;

    typedef struct packed {
        addr_t addr;
        byte_t data;
        logic  on_short;
    } slot_t;

    typedef struct packed {
        logic  wide;
        addr_t pc;
        sptr_t ssp;
        addr_t lsp;
    } arch_t;

    // Which push sequence a request needs; the suffix only matters in 16-bit mode.
    function automatic flav_e pick_flavor(req_t r);
        if (!r.cond)     return FLAV_SKIP;
        else if (r.wide) return FLAV_LONG;
        else if (r.sfx)  return FLAV_SHORT_MARK;
        else             return FLAV_SHORT;
    endfunction

    // A 16-bit-mode pointer placed into the 24-bit space behind the base page.
    function automatic addr_t paged(byte_t base, sptr_t ptr);
        return {base, ptr};
    endfunction

    function automatic byte_t byte_at(addr_t v, int k);
        return v[k*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/xcall_planner.sv
module xcall_planner
    import xcall_pkg::*;
(
    input  req_t              req,
    output slot_t             slots [MAX_WR],
    output logic [CNT_W-1:0]  n_wr,
    output arch_t             fin
);

    flav_e flav;

    always_comb begin
        flav = pick_flavor(req);
        for (int k = 0; k < MAX_WR; k++) begin
            slots[k] = '0;
        end
        n_wr     = '0;
        fin.wide = req.wide;
        fin.pc   = req.wide ? req.nxt : paged(req.base, req.nxt[SHORT_W-1:0]);
        fin.ssp  = req.ssp;
        fin.lsp  = req.lsp;

        case (flav)
            FLAV_SHORT, FLAV_SHORT_MARK: begin
                // two bytes of the return address, high byte first, downward
                for (int k = 0; k < 2; k++) begin
                    slots[k].addr     = paged(req.base, req.ssp - sptr_t'(k + 1));
                    slots[k].data     = byte_at(req.nxt, 1 - k);
                    slots[k].on_short = 1'b1;
                end
                n_wr    = CNT_W'(2);
                fin.ssp = req.ssp - sptr_t'(2);
                fin.pc  = {req.base, req.mid, req.lo};
                if (flav == FLAV_SHORT_MARK) begin
                    slots[2].addr     = req.lsp - addr_t'(1);
                    slots[2].data     = MODE16_MARK;
                    slots[2].on_short = 1'b0;
                    n_wr              = CNT_W'(3);
                    fin.lsp           = req.lsp - addr_t'(1);
                end
            end
            FLAV_LONG: begin
                for (int k = 0; k < 3; k++) begin
                    slots[k].addr     = req.lsp - addr_t'(k + 1);
                    slots[k].data     = byte_at(req.nxt, 2 - k);
                    slots[k].on_short = 1'b0;
                end
                n_wr    = CNT_W'(3);
                fin.lsp = req.lsp - addr_t'(3);
                fin.pc  = {req.hi, req.mid, req.lo};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xcall_ctrl.sv
module xcall_ctrl
    import xcall_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  n_wr,
    output st_e               state,
    output logic [SLOT_W-1:0] idx,
    output logic              accept,
    output logic              load_res
);

    logic [CNT_W-1:0] last_idx;
    logic             at_last;

    assign last_idx = n_wr - CNT_W'(1);
    assign at_last  = (CNT_W'(idx) == last_idx);
    assign accept   = (state == ST_IDLE) && start;
    assign load_res = (accept && (n_wr == '0)) || ((state == ST_PUSH) && at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (start) state <= (n_wr == '0) ? ST_DONE : ST_PUSH;
                end
                ST_PUSH: begin
                    if (at_last) begin
                        state <= ST_DONE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + SLOT_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    idx   <= '0;
                end
            endcase
        end
    end

    // R7: the slot index never runs past the planned write count
    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH) |-> (CNT_W'(idx) < n_wr));

    // R7: the done state lasts a single cycle
    a_r7_done_once: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/xcall_result.sv
module xcall_result
    import xcall_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  arch_t fin,
    output arch_t res
);

    // R10: cleared on reset
    always_ff @(posedge clk) begin
        if (rst)       res <= '0;
        else if (load) res <= fin;
    end

endmodule

// File: rtl/xcall_seq.sv
module xcall_seq
    import xcall_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cond_true,
    input  logic              wide_mode,
    input  logic              short_sfx,
    input  logic [BYTE_W-1:0] tgt_lo,
    input  logic [BYTE_W-1:0] tgt_mid,
    input  logic [BYTE_W-1:0] tgt_hi,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [BYTE_W-1:0] page_base,
    input  logic [SHORT_W-1:0] ssp_in,
    input  logic [ADDR_W-1:0] lsp_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SHORT_W-1:0] ssp_out,
    output logic [ADDR_W-1:0] lsp_out,
    output logic              wide_out
);

    req_t              req_in, req_q, req_cur;
    slot_t             slots [MAX_WR];
    slot_t             cur;
    logic [CNT_W-1:0]  n_wr;
    arch_t             fin, res;
    st_e               state;
    logic [SLOT_W-1:0] idx;
    logic              accept, load_res;

    assign req_in = '{cond: cond_true, wide: wide_mode, sfx: short_sfx,
                      lo: tgt_lo, mid: tgt_mid, hi: tgt_hi, nxt: next_pc,
                      base: page_base, ssp: ssp_in, lsp: lsp_in};

    // R8: request frozen once accepted
    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= req_in;
    end

    // The planner sees the live inputs while idle so an empty plan can finish at once.
    assign req_cur = (state == ST_IDLE) ? req_in : req_q;

    xcall_planner u_plan (
        .req   (req_cur),
        .slots (slots),
        .n_wr  (n_wr),
        .fin   (fin)
    );

    xcall_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .n_wr     (n_wr),
        .state    (state),
        .idx      (idx),
        .accept   (accept),
        .load_res (load_res)
    );

    xcall_result u_res (
        .clk  (clk),
        .rst  (rst),
        .load (load_res),
        .fin  (fin),
        .res  (res)
    );

    assign cur      = slots[idx];
    assign wr_en    = (state == ST_PUSH);
    assign wr_addr  = wr_en ? cur.addr : '0;
    assign wr_data  = wr_en ? cur.data : '0;
    assign done     = (state == ST_DONE);
    assign pc_out   = res.pc;
    assign ssp_out  = res.ssp;
    assign lsp_out  = res.lsp;
    assign wide_out = res.wide;

    // R1: a false condition never produces write cycles
    a_r1_push_needs_cond: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> req_q.cond);

    // R7: done is a one-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a busy sequencer keeps its captured request
    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(req_q));

    // R2 / R9: short-stack writes stay in the base page
    a_r2_short_page: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur.on_short) |-> (wr_addr[ADDR_W-1:SHORT_W] == req_q.base));

    // R6: the reported mode is the mode of the accepted call
    a_r6_mode_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> (wide_out == req_q.wide));

endmodule

// File: tb/tb_xcall_seq.sv
module tb_xcall_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, cond_true, wide_mode, short_sfx;
    logic [7:0]  tgt_lo, tgt_mid, tgt_hi, page_base;
    logic [23:0] next_pc, lsp_in;
    logic [15:0] ssp_in;
    logic        wr_en, done, wide_out;
    logic [23:0] wr_addr, pc_out, lsp_out;
    logic [7:0]  wr_data;
    logic [15:0] ssp_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xcall_seq dut (
        .clk(clk), .rst(rst), .start(start), .cond_true(cond_true),
        .wide_mode(wide_mode), .short_sfx(short_sfx), .tgt_lo(tgt_lo),
        .tgt_mid(tgt_mid), .tgt_hi(tgt_hi), .next_pc(next_pc),
        .page_base(page_base), .ssp_in(ssp_in), .lsp_in(lsp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .pc_out(pc_out), .ssp_out(ssp_out), .lsp_out(lsp_out),
        .wide_out(wide_out)
    );

    typedef struct packed {
        logic        cond;
        logic        wide;
        logic        sfx;
        logic        wrap;
        logic [7:0]  lo;
        logic [7:0]  mid;
        logic [7:0]  hi;
        logic [23:0] nxt;
        logic [7:0]  base;
        logic [15:0] ssp;
        logic [23:0] lsp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33, 24'h45_1234, 8'h45, 16'h8000, 24'h10_0000},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'h44, 8'h55, 8'h66, 24'h9A_0203, 8'h7E, 16'h4000, 24'h20_0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 8'h88, 8'h99, 24'hAB_CDEF, 8'h01, 16'h1000, 24'h30_0000},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'hAA, 8'hBB, 8'hCC, 24'h12_3456, 8'h02, 16'h2000, 24'h40_0000},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h34, 8'h12, 8'hEE, 24'h45_A1B2, 8'h45, 16'h8000, 24'h10_0000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h78, 8'h56, 8'hDD, 24'h7E_C3D4, 8'h7E, 16'h4000, 24'h20_0010},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'hBC, 8'h9A, 8'h5C, 24'hAB_CDEF, 8'h01, 16'h1000, 24'h30_0000},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'hF0, 8'hDE, 8'h3F, 24'h12_3456, 8'h02, 16'h2000, 24'h40_0005},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 8'h02, 8'h03, 24'hC0_5A6B, 8'hC0, 16'h0001, 24'h00_1000},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h04, 8'h05, 8'h06, 24'h65_4321, 8'h33, 16'h0500, 24'h00_0001},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h07, 8'h08, 8'h09, 24'h3C_7C8D, 8'h3C, 16'h0000, 24'h00_0000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cond_true = v.cond; wide_mode = v.wide; short_sfx = v.sfx;
        tgt_lo = v.lo; tgt_mid = v.mid; tgt_hi = v.hi; next_pc = v.nxt;
        page_base = v.base; ssp_in = v.ssp; lsp_in = v.lsp;
    endtask

    // Expected outcome worked out from the requirements.
    task automatic model(input vec_t v, output int n, output logic [23:0] ea [4],
                         output logic [7:0] ed [4], output logic [23:0] pc,
                         output logic [15:0] ssp, output logic [23:0] lsp);
        n = 0; ssp = v.ssp; lsp = v.lsp;
        for (int i = 0; i < 4; i++) begin ea[i] = '0; ed[i] = '0; end
        if (!v.cond) begin
            pc = v.wide ? v.nxt : {v.base, v.nxt[15:0]};
        end else if (v.wide) begin
            ea[0] = v.lsp - 24'd1; ed[0] = v.nxt[23:16];
            ea[1] = v.lsp - 24'd2; ed[1] = v.nxt[15:8];
            ea[2] = v.lsp - 24'd3; ed[2] = v.nxt[7:0];
            n = 3; lsp = v.lsp - 24'd3; pc = {v.hi, v.mid, v.lo};
        end else begin
            ea[0] = {v.base, 16'(v.ssp - 16'd1)}; ed[0] = v.nxt[15:8];
            ea[1] = {v.base, 16'(v.ssp - 16'd2)}; ed[1] = v.nxt[7:0];
            n = 2; ssp = v.ssp - 16'd2; pc = {v.base, v.mid, v.lo};
            if (v.sfx) begin
                ea[2] = v.lsp - 24'd1; ed[2] = 8'h02;
                n = 3; lsp = v.lsp - 24'd1;
            end
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.wrap)           return "R9";
        if (!v.cond)          return "R1";
        if (v.wide && v.sfx)  return "R5";
        if (v.wide)           return "R3";
        if (v.sfx)            return "R4";
        return "R2";
    endfunction

    // Run one call; optionally raise start again with a different request mid-flight.
    task automatic run_call(input vec_t v, input bit poke_busy, input bit poke_done);
        int n;
        logic [23:0] ea [4];
        logic [7:0]  ed [4];
        logic [23:0] epc, elsp;
        logic [15:0] essp;
        string tg;
        vec_t other;
        tg = tag_of(v);
        model(v, n, ea, ed, epc, essp, elsp);
        other = v;
        other.cond = 1'b1; other.wide = ~v.wide; other.ssp = 16'h1234;
        other.lsp = 24'h55_5555; other.lo = 8'h5A;
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < n; c++) begin
            if (poke_busy && c == 0) begin
                drive(other);
                start = 1'b1;
            end
            chk(wr_en === 1'b1 && done === 1'b0, "R7", "write strobe", {30'd0, wr_en, done}, 32'h2);
            chk(wr_addr === ea[c], tg, "write address", 32'(wr_addr), 32'(ea[c]));
            chk(wr_data === ed[c], tg, "write data", 32'(wr_data), 32'(ed[c]));
            @(negedge clk);
            start = 1'b0;
        end
        chk(done === 1'b1 && wr_en === 1'b0, "R7", "done after writes", {30'd0, wr_en, done}, 32'h1);
        chk(pc_out === epc, tg, "pc_out", 32'(pc_out), 32'(epc));
        chk(ssp_out === essp, tg, "ssp_out", 32'(ssp_out), 32'(essp));
        chk(lsp_out === elsp, tg, "lsp_out", 32'(lsp_out), 32'(elsp));
        chk(wide_out === v.wide, "R6", "wide_out", 32'(wide_out), 32'(v.wide));
        if (poke_done) begin
            drive(other);
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && wr_en === 1'b0, "R7", "done single cycle", {30'd0, wr_en, done}, 32'h0);
        if (poke_busy || poke_done) begin
            @(negedge clk);
            chk(done === 1'b0 && wr_en === 1'b0, "R8", "no second call", {30'd0, wr_en, done}, 32'h0);
            chk(pc_out === epc && ssp_out === essp && lsp_out === elsp, "R8",
                "results kept", 32'(pc_out), 32'(epc));
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t v;
        start = 0;
        drive('0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(wr_en === 1'b0 && done === 1'b0, "R10", "strobes after reset", {30'd0, wr_en, done}, 32'h0);
        chk(pc_out === 24'd0 && ssp_out === 16'd0, "R10", "pc/ssp after reset", 32'(pc_out), 32'h0);
        chk(lsp_out === 24'd0 && wide_out === 1'b0, "R10", "lsp/mode after reset", 32'(lsp_out), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_call(VECS[i], 1'b0, 1'b0);
        end

        // R8: start raised during a write cycle and during the done cycle
        run_call(VECS[6], 1'b1, 1'b0);
        run_call(VECS[5], 1'b0, 1'b1);
        run_call(VECS[1], 1'b0, 1'b1);

        // R5: same request with and without the suffix gives identical writes
        v = VECS[6];
        v.sfx = 1'b1;
        run_call(v, 1'b0, 1'b0);

        // R1 after a taken call: outputs return to the non-taken values
        v = VECS[4];
        v.cond = 1'b0;
        run_call(v, 1'b0, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule